// File: doc/BRIEF.md
# Acquisition Cycle Sequencer

This block is the central timing source for the readout of several detector subsystems that share one master clock, treated as the bunch-crossing clock. It opens and closes acquisition cycles and sends each cycle to a set of output ports, one per subsystem. Each port gets a one-cycle start pulse, a one-cycle stop pulse and a validation strobe that forwards the external trigger while that port's window is open. Every port has its own programmable start delay and stop delay, so subsystems with different pipeline depths see their windows aligned to their own needs.

Two running modes are offered. In periodic mode the cycle repeats every `period_cyc` clocks and each window lasts `live_cyc` clocks; typical use is a few hertz with a window of about a millisecond, but both values are free. In spill mode a cycle can begin only while the external spill gate is high. The window closes when `live_cyc` expires or when the gate falls, whichever comes first. The next start then waits until every unmasked downstream busy line has cleared. Busy lines are synchronised with two flops. Each line can be read as a plain level, or as an oscillating line that counts as busy for a programmable number of clocks after each edge.

A readable cycle counter counts starts and is cleared when a run begins. Dropping `run_en` closes an open window cleanly and returns the sequencer to idle. All pins are plain control and status pins: the block carries no data stream, so there is no valid/ready flow control and no back-pressure.

Top module: `acq_cycle_seq`

## Requirements
- R1: In periodic mode (`mode_spill`=0), successive start pulses on a port are exactly `period_cyc` clocks apart. After `run_en` is first sampled high at edge E, the internal cycle start occurs at edge E+1.
- R2: A port's stop pulse comes `live_cyc` + stop delay clocks after the internal cycle start, plus one clock. With a start at edge E+1 this is edge E+2+`live_cyc`+stop delay.
- R3: Port i takes its start delay from `start_dly[i*8 +: 8]` and its stop delay from `stop_dly[i*8 +: 8]`. A port start pulse comes 1 + start delay clocks after the internal cycle start, and every port pulse lasts exactly one clock.
- R4: In spill mode (`mode_spill`=1), no cycle starts while `spill_gate` is low. If the gate is sampled high at edge G with no busy, the port i start appears at edge G+1+start delay.
- R5: In spill mode, after a stop, no new start is issued while any unmasked busy is asserted. A start follows once all busy lines have cleared.
- R6: A port with `busy_osc`=1 counts as busy for `osc_timeout` clocks after each edge seen on its line. A line held steady at either level stops counting as busy after that timeout.
- R7: A port with `busy_osc`=0 counts as busy for as long as its synchronised line is high.
- R8: A port with `busy_mask`=1 never blocks a start, whatever its busy line does, and it still receives its start and stop pulses.
- R9: If the spill gate is sampled low at edge G while a window is open, the cycle stops at edge G, the port i stop appears at edge G+1+stop delay, and no further start is issued while the gate stays low.
- R10: If `run_en` is sampled low at edge D while a window is open, the cycle stops at edge D, the port stops follow their stop delays, and no further start is issued.
- R11: `port_valid[i]` is high one clock after `trig_in` was high while port i's window was open. The window runs from its start pulse up to the clock before its stop pulse.
- R12: `cycle_count` rises by one with each cycle start and is cleared when a run begins, that is, when `run_en` is sampled high in idle.
- R13: After reset all port pulses, validation strobes and `cycle_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master (bunch-crossing) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run enable; low forces a clean stop and idle |
| mode_spill | input | 1 | 0 = periodic mode, 1 = spill mode |
| spill_gate | input | 1 | Spill gate, synchronous to clk |
| period_cyc | input | 24 | Periodic cycle length in clocks |
| live_cyc | input | 24 | Live window length in clocks |
| start_dly | input | 24 | Per-port start delay, port i at bits [i*8 +: 8] |
| stop_dly | input | 24 | Per-port stop delay, port i at bits [i*8 +: 8] |
| busy_in | input | 3 | Raw busy line from each downstream unit |
| busy_osc | input | 3 | Per-port busy style: 1 = oscillating, 0 = level |
| busy_mask | input | 3 | Per-port busy mask: 1 = ignore that port's busy |
| osc_timeout | input | 8 | Oscillating-busy hold window in clocks |
| trig_in | input | 1 | External trigger, synchronous to clk |
| port_start | output | 3 | Delayed start pulse per port |
| port_stop | output | 3 | Delayed stop pulse per port |
| port_valid | output | 3 | Validation strobe per port |
| cycle_count | output | 16 | Starts since the run began |

## Verification
Periodic mode is run with random period, window length and per-port delays. Comparing each port's first start, second start and first stop against computed edge numbers separates a wrong period from a wrong window length from a per-port delay error. In spill mode, holding the gate low and then raising it and dropping it mid-window separates gate-following from timer-following. Three busy patterns are applied: a level busy held across a stop, a rapidly toggling line on an oscillating port followed by a steady high level, and a masked busy port. Together they show that each busy style blocks starts only when it should.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_TRIG = 3'd1,
    ST_ACTIVE    = 3'd2,
    ST_STOPPING  = 3'd3,
    ST_WAIT_BUSY = 3'd4
  } seq_state_e;
endpackage

// File: rtl/acq_busy_port.sv
module acq_busy_port #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_raw,
  input  logic            osc_sel,
  input  logic            mask,
  input  logic [TO_W-1:0] timeout,
  output logic            busy_o
);
  logic [1:0]      sync_q;
  logic            line_d;
  logic [TO_W-1:0] hold_cnt;
  logic            edge_seen;

  assign edge_seen = sync_q[1] ^ line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      line_d   <= 1'b0;
      hold_cnt <= '0;
      busy_o   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], busy_raw};
      line_d <= sync_q[1];
      if (edge_seen) begin
        hold_cnt <= timeout;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - TO_W'(1);
      end
      busy_o <= !mask && (osc_sel ? (hold_cnt != '0) : sync_q[1]);
    end
  end
endmodule

// File: rtl/acq_port_delay.sv
module acq_port_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_stop,
  input  logic             trig_in,
  input  logic [DLY_W-1:0] start_dly,
  input  logic [DLY_W-1:0] stop_dly,
  output logic             port_start,
  output logic             port_stop,
  output logic             port_valid,
  output logic             pending
);
  logic             st_pend, sp_pend;
  logic [DLY_W-1:0] st_cnt, sp_cnt;
  logic             st_fire, sp_fire;
  logic             win_q;

  always_comb begin
    st_fire = cyc_start ? (start_dly == '0) : (st_pend && st_cnt == '0);
    sp_fire = cyc_stop  ? (stop_dly  == '0) : (sp_pend && sp_cnt == '0);
  end

  assign pending = st_pend | sp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pend    <= 1'b0;
      sp_pend    <= 1'b0;
      st_cnt     <= '0;
      sp_cnt     <= '0;
      win_q      <= 1'b0;
      port_start <= 1'b0;
      port_stop  <= 1'b0;
      port_valid <= 1'b0;
    end else begin
      port_start <= st_fire;
      port_stop  <= sp_fire;
      port_valid <= trig_in & win_q;

      if (cyc_start) begin
        st_pend <= (start_dly != '0);
        st_cnt  <= start_dly - DLY_W'(1);
      end else if (st_pend) begin
        if (st_cnt == '0) st_pend <= 1'b0;
        else              st_cnt  <= st_cnt - DLY_W'(1);
      end

      if (cyc_stop) begin
        sp_pend <= (stop_dly != '0);
        sp_cnt  <= stop_dly - DLY_W'(1);
      end else if (sp_pend) begin
        if (sp_cnt == '0) sp_pend <= 1'b0;
        else              sp_cnt  <= sp_cnt - DLY_W'(1);
      end

      if (st_fire) win_q <= 1'b1;
      if (sp_fire) win_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acq_cycle_fsm.sv
module acq_cycle_fsm
  import acq_pkg::*;
#(
  parameter int TMR_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_spill,
  input  logic             spill_gate,
  input  logic [TMR_W-1:0] period_cyc,
  input  logic [TMR_W-1:0] live_cyc,
  input  logic             busy_any,
  input  logic             pending_any,
  output logic             cyc_start,
  output logic             cyc_stop,
  output logic             fsm_active,
  output logic [CNT_W-1:0] cycle_count
);
  seq_state_e       state;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W:0]   tmr_nx;
  logic             period_due, live_done, may_start;

  always_comb begin
    tmr_nx     = {1'b0, tmr} + {{TMR_W{1'b0}}, 1'b1};
    period_due = tmr_nx >= {1'b0, period_cyc};
    live_done  = tmr_nx >= {1'b0, live_cyc};
    may_start  = mode_spill ? (spill_gate && !busy_any) : period_due;
  end

  assign fsm_active = (state == ST_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tmr         <= '0;
      cyc_start   <= 1'b0;
      cyc_stop    <= 1'b0;
      cycle_count <= '0;
    end else begin
      cyc_start <= 1'b0;
      cyc_stop  <= 1'b0;
      if (state != ST_IDLE) tmr <= tmr_nx[TMR_W-1:0];
      unique case (state)
        ST_IDLE: begin
          if (run_en) begin
            state       <= ST_WAIT_TRIG;
            tmr         <= period_cyc - TMR_W'(1);
            cycle_count <= '0;
          end
        end
        ST_WAIT_TRIG: begin
          if (!run_en) begin
            state <= ST_IDLE;
          end else if (may_start) begin
            state       <= ST_ACTIVE;
            cyc_start   <= 1'b1;
            tmr         <= '0;
            cycle_count <= cycle_count + CNT_W'(1);
          end
        end
        ST_ACTIVE: begin
          if (!run_en || (mode_spill && !spill_gate) || live_done) begin
            state    <= ST_STOPPING;
            cyc_stop <= 1'b1;
          end
        end
        ST_STOPPING: begin
          if (!pending_any && !cyc_stop) state <= ST_WAIT_BUSY;
        end
        ST_WAIT_BUSY: begin
          if (!run_en) begin
            state <= ST_IDLE;
          end else if (!mode_spill || !busy_any) begin
            state <= ST_WAIT_TRIG;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acq_cycle_seq.sv
module acq_cycle_seq #(
  parameter int NPORT = 3,
  parameter int DLY_W = 8,
  parameter int TMR_W = 24,
  parameter int TO_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_en,
  input  logic                   mode_spill,
  input  logic                   spill_gate,
  input  logic [TMR_W-1:0]       period_cyc,
  input  logic [TMR_W-1:0]       live_cyc,
  input  logic [NPORT*DLY_W-1:0] start_dly,
  input  logic [NPORT*DLY_W-1:0] stop_dly,
  input  logic [NPORT-1:0]       busy_in,
  input  logic [NPORT-1:0]       busy_osc,
  input  logic [NPORT-1:0]       busy_mask,
  input  logic [TO_W-1:0]        osc_timeout,
  input  logic                   trig_in,
  output logic [NPORT-1:0]       port_start,
  output logic [NPORT-1:0]       port_stop,
  output logic [NPORT-1:0]       port_valid,
  output logic [CNT_W-1:0]       cycle_count
);
  localparam int DLY_BUS = NPORT * DLY_W;

  logic [NPORT-1:0] busy_vec;
  logic [NPORT-1:0] pend_vec;
  logic             busy_any, pending_any;
  logic             cyc_start, cyc_stop, fsm_active;

  assign busy_any    = |busy_vec;
  assign pending_any = |pend_vec;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    acq_busy_port #(.TO_W(TO_W)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_raw (busy_in[i]),
      .osc_sel  (busy_osc[i]),
      .mask     (busy_mask[i]),
      .timeout  (osc_timeout),
      .busy_o   (busy_vec[i])
    );

    acq_port_delay #(.DLY_W(DLY_W)) u_dly (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_start  (cyc_start),
      .cyc_stop   (cyc_stop),
      .trig_in    (trig_in),
      .start_dly  (start_dly[i*DLY_W +: DLY_W]),
      .stop_dly   (stop_dly[i*DLY_W +: DLY_W]),
      .port_start (port_start[i]),
      .port_stop  (port_stop[i]),
      .port_valid (port_valid[i]),
      .pending    (pend_vec[i])
    );
  end

  acq_cycle_fsm #(.TMR_W(TMR_W), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .mode_spill  (mode_spill),
    .spill_gate  (spill_gate),
    .period_cyc  (period_cyc),
    .live_cyc    (live_cyc),
    .busy_any    (busy_any),
    .pending_any (pending_any),
    .cyc_start   (cyc_start),
    .cyc_stop    (cyc_stop),
    .fsm_active  (fsm_active),
    .cycle_count (cycle_count)
  );

  if (DLY_BUS < NPORT) begin : g_bad_cfg
    $error("DLY_W must be at least 1");
  end
endmodule

// File: rtl/acq_cycle_seq_chk.sv
module acq_cycle_seq_chk #(
  parameter int NPORT = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             mode_spill,
  input logic             spill_gate,
  input logic             trig_in,
  input logic [NPORT-1:0] port_start,
  input logic [NPORT-1:0] port_valid,
  input logic [CNT_W-1:0] cycle_count,
  input logic             cyc_start,
  input logic             cyc_stop,
  input logic             busy_any,
  input logic             fsm_active
);
  AST_SPILL_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_spill && !spill_gate) |=> !cyc_start);  // R4
  AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_spill && busy_any) |=> !cyc_start);  // R5
  AST_SPILL_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_active && mode_spill && !spill_gate) |=> cyc_stop);  // R9
  AST_RUN_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !cyc_start);  // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (cycle_count == $past(cycle_count) + CNT_W'(1)));  // R12

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      port_start[i] |=> !port_start[i]);  // R3
    AST_VALID_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[i] |-> $past(trig_in));  // R11
  end
endmodule

bind acq_cycle_seq acq_cycle_seq_chk #(.NPORT(NPORT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en      (run_en),
  .mode_spill  (mode_spill),
  .spill_gate  (spill_gate),
  .trig_in     (trig_in),
  .port_start  (port_start),
  .port_valid  (port_valid),
  .cycle_count (cycle_count),
  .cyc_start   (cyc_start),
  .cyc_stop    (cyc_stop),
  .busy_any    (busy_any),
  .fsm_active  (fsm_active)
);

// File: tb/tb_acq_cycle_seq.sv
module tb_acq_cycle_seq;
  localparam int NP = 3;
  localparam int DW = 8;
  localparam int TW = 24;
  localparam int OW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, mode_spill = 1'b0, spill_gate = 1'b0, trig_in = 1'b0;
  logic [TW-1:0] period_cyc = '0, live_cyc = '0;
  logic [NP*DW-1:0] start_dly = '0, stop_dly = '0;
  logic [NP-1:0] busy_in = '0, busy_osc = '0, busy_mask = '0;
  logic [OW-1:0] osc_timeout = '0;
  logic [NP-1:0] port_start, port_stop, port_valid;
  logic [CW-1:0] cycle_count;

  always #10 clk = ~clk;

  acq_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_spill(mode_spill),
    .spill_gate(spill_gate), .period_cyc(period_cyc), .live_cyc(live_cyc),
    .start_dly(start_dly), .stop_dly(stop_dly), .busy_in(busy_in),
    .busy_osc(busy_osc), .busy_mask(busy_mask), .osc_timeout(osc_timeout),
    .trig_in(trig_in), .port_start(port_start), .port_stop(port_stop),
    .port_valid(port_valid), .cycle_count(cycle_count)
  );

  int ncyc = 0;
  int checks = 0, failures = 0;
  bit done = 1'b0;
  int first_start[NP], second_start[NP], first_stop[NP], nstart[NP], vcount[NP];
  int sd[NP], pd[NP];

  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (port_start[i]) begin
        if (nstart[i] == 0) first_start[i] = ncyc;
        else if (nstart[i] == 1) second_start[i] = ncyc;
        nstart[i]++;
      end
      if (port_stop[i] && first_stop[i] < 0) first_stop[i] = ncyc;
      if (port_valid[i] && (first_stop[i] < 0 || ncyc <= first_stop[i])) vcount[i]++;
    end
  end

  task automatic clear_mon();
    for (int i = 0; i < NP; i++) begin
      first_start[i] = -1; second_start[i] = -1; first_stop[i] = -1;
      nstart[i] = 0; vcount[i] = 0;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_dly();
    for (int i = 0; i < NP; i++) begin
      start_dly[i*DW +: DW] = DW'(sd[i]);
      stop_dly[i*DW +: DW]  = DW'(pd[i]);
    end
  endtask

  task automatic end_run();
    @(negedge clk);
    run_en = 1'b0; spill_gate = 1'b0; trig_in = 1'b0; busy_in = '0;
    wait_cyc(400);
    busy_osc = '0; busy_mask = '0;
    clear_mon();
  endtask

  function automatic int exp_periodic_start(input int e, input int d);
    return e + 2 + d;
  endfunction

  function automatic int exp_periodic_stop(input int e, input int live, input int d);
    return e + 2 + live + d;
  endfunction

  function automatic int exp_count(input int t, input int e, input int per);
    return (t - (e + 1)) / per + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e, g, b, t, per, live;
    void'($urandom(32'h5eed));
    clear_mon();
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(port_start == '0, "R13 port_start", int'(port_start), 0);
    chk(port_stop == '0, "R13 port_stop", int'(port_stop), 0);
    chk(port_valid == '0, "R13 port_valid", int'(port_valid), 0);
    chk(cycle_count == '0, "R13 cycle_count", int'(cycle_count), 0);

    // Random periodic trials: R1 R2 R3 R11 R12
    for (int trial = 0; trial < 4; trial++) begin
      per  = 70 + int'($urandom % 100);
      live = 16 + int'($urandom % 30);
      for (int i = 0; i < NP; i++) begin
        sd[i] = int'($urandom % 16);
        pd[i] = int'($urandom % 16);
      end
      @(negedge clk);
      mode_spill = 1'b0; period_cyc = TW'(per); live_cyc = TW'(live);
      load_dly(); trig_in = 1'b1;
      e = ncyc + 1;
      run_en = 1'b1;
      wait_cyc(2 * per + 40);
      t = ncyc;
      for (int i = 0; i < NP; i++) begin
        chk(first_start[i] == exp_periodic_start(e, sd[i]), "R3 first start",
            first_start[i], exp_periodic_start(e, sd[i]));
        chk(second_start[i] - first_start[i] == per, "R1 start spacing",
            second_start[i] - first_start[i], per);
        chk(first_stop[i] == exp_periodic_stop(e, live, pd[i]), "R2 first stop",
            first_stop[i], exp_periodic_stop(e, live, pd[i]));
        chk(vcount[i] == live + pd[i] - sd[i], "R11 valid count",
            vcount[i], live + pd[i] - sd[i]);
      end
      chk(int'(cycle_count) == exp_count(t, e, per), "R12 cycle count",
          int'(cycle_count), exp_count(t, e, per));
      end_run();
    end

    // R10: run disable mid-window
    @(negedge clk);
    per = 300; live = 200;
    sd = '{0, 3, 0}; pd = '{0, 5, 2};
    mode_spill = 1'b0; period_cyc = TW'(per); live_cyc = TW'(live); load_dly();
    e = ncyc + 1;
    run_en = 1'b1;
    wait_cyc(30);
    g = ncyc + 1;
    run_en = 1'b0;
    wait_cyc(400);
    for (int i = 0; i < NP; i++)
      chk(first_stop[i] == g + 1 + pd[i], "R10 stop on run disable", first_stop[i], g + 1 + pd[i]);
    chk(nstart[0] == 1, "R10 no restart", nstart[0], 1);
    chk(cycle_count == CW'(1), "R10 count kept", int'(cycle_count), 1);
    end_run();

    // R4 / R9: spill gate
    @(negedge clk);
    sd = '{2, 0, 7}; pd = '{0, 4, 1};
    mode_spill = 1'b1; live_cyc = TW'(1000); load_dly();
    run_en = 1'b1;
    wait_cyc(50);
    chk(nstart[0] == 0, "R4 no start with gate low", nstart[0], 0);
    g = ncyc + 1;
    spill_gate = 1'b1;
    wait_cyc(30);
    for (int i = 0; i < NP; i++)
      chk(first_start[i] == g + 1 + sd[i], "R4 start after gate", first_start[i], g + 1 + sd[i]);
    g = ncyc + 1;
    spill_gate = 1'b0;
    wait_cyc(60);
    for (int i = 0; i < NP; i++)
      chk(first_stop[i] == g + 1 + pd[i], "R9 stop on spill end", first_stop[i], g + 1 + pd[i]);
    chk(nstart[0] == 1, "R9 no start after spill end", nstart[0], 1);
    end_run();

    // R7 / R5: level busy
    @(negedge clk);
    sd = '{0, 0, 0}; pd = '{0, 0, 0};
    mode_spill = 1'b1; live_cyc = TW'(20); load_dly();
    run_en = 1'b1;
    busy_in[0] = 1'b1;
    wait_cyc(5);
    spill_gate = 1'b1;
    wait_cyc(40);
    chk(nstart[0] == 0, "R7 level busy blocks", nstart[0], 0);
    b = ncyc + 1;
    busy_in[0] = 1'b0;
    wait_cyc(6);
    busy_in[0] = 1'b1;
    wait_cyc(80);
    chk(first_start[0] > b && first_start[0] <= b + 10, "R7 start after busy clear",
        first_start[0], b + 4);
    chk(nstart[0] == 1, "R5 busy holds next start", nstart[0], 1);
    busy_in[0] = 1'b0;
    wait_cyc(20);
    chk(nstart[0] == 2, "R5 start after busy clears", nstart[0], 2);
    end_run();

    // R6: oscillating busy
    @(negedge clk);
    mode_spill = 1'b1; live_cyc = TW'(20); busy_osc = 3'b010; osc_timeout = OW'(20);
    run_en = 1'b1;
    for (int k = 0; k < 31; k++) begin
      busy_in[1] = ~busy_in[1];
      if (k == 2) spill_gate = 1'b1;
      wait_cyc(4);
    end
    chk(nstart[1] == 0, "R6 toggling busy blocks", nstart[1], 0);
    wait_cyc(40);
    chk(nstart[1] >= 1, "R6 steady line times out", nstart[1], 1);
    end_run();

    // R8: masked busy
    @(negedge clk);
    mode_spill = 1'b1; live_cyc = TW'(20); busy_mask = 3'b100;
    busy_in[2] = 1'b1;
    run_en = 1'b1;
    wait_cyc(5);
    spill_gate = 1'b1;
    wait_cyc(30);
    chk(nstart[0] >= 1, "R8 masked busy ignored", nstart[0], 1);
    chk(nstart[2] >= 1, "R8 masked port still pulses", nstart[2], 1);
    end_run();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule